// File: doc/BRIEF.md
# Stereo Cross-Path Attenuation Matrix

This block mixes a stereo pair through a 2x2 matrix. Each output channel is the sum of two weighted terms, one from each input channel. Each of the four paths (left in to left out, left in to right out, right in to left out, right in to right out) carries its own 7-bit attenuation code. A code of zero passes the path at unity gain. The all-ones code removes the path entirely. Each code between those two steps the gain down by about half a decibel.

Codes are loaded one byte at a time through a plain write port that carries a two-bit path select. Audio enters as a pair of signed 16-bit words with a valid strobe. It leaves as a saturated signed pair with its own valid strobe after a fixed pipeline delay. The gains are frozen for each sample pair at the moment that pair is accepted, so a write never splits one pair between old and new settings.

Top module: `xfeed_matrix`

## Requirements
- R1: While reset is asserted, and afterwards until the first result, outValid, outL, outR and wrErr are 0. Reset loads the codes so that audio passes straight through with no cross-feed: left-to-left and right-to-right at 0, left-to-right and right-to-left at 0x7F.
- R2: A write with wrEn high and wrData bit 7 clear stores wrData[6:0] as the code of the path that wrAddr selects: 0 left-to-left, 1 left-to-right, 2 right-to-left, 3 right-to-right.
- R3: A path gain is 1.0 for code 0 and 0.0 for code 0x7F. For code c from 1 to 0x7E it is M[c mod 12] >> (c div 12), with M[k] = round(32768 * 10^(-k/40)) in Q1.15. A path term is floor(sample * gain / 32768).
- R4: outL is the term of left-to-left on inL plus the term of right-to-left on inR. outR is the term of left-to-right on inL plus the term of right-to-right on inR.
- R5: Each sum saturates to the signed 16-bit range, -32768 to 32767.
- R6: A write with wrData bit 7 set leaves every code unchanged, and wrErr is high for exactly the one cycle that follows that write.
- R7: A pair accepted at a rising edge with inValid high shows up on outL/outR with outValid high after the third rising edge, counting the accepting edge as the first. outValid is high for one cycle per accepted pair.
- R8: outL and outR hold their last value on every cycle in which outValid is low.
- R9: Each pair uses the codes that are stored when it is accepted. A write in the same cycle as inValid, or while the pair is in the pipeline, does not change that pair. It does apply to every pair accepted later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Code write strobe |
| wrAddr | input | 2 | Path select for the write |
| wrData | input | 8 | Code byte; bit 7 must be clear |
| wrErr | output | 1 | One-cycle flag for a rejected write |
| inValid | input | 1 | Input pair strobe |
| inL | input | 16 | Left input sample, signed |
| inR | input | 16 | Right input sample, signed |
| outValid | output | 1 | Output pair strobe |
| outL | output | 16 | Left output sample, signed |
| outR | output | 16 | Right output sample, signed |

## Verification
There are two result timings. A mixed pair is due with outValid three rising edges after the edge that accepts it: the input capture, the product stage and the sum stage. wrErr is due one edge after the write. The bench drives inputs on falling edges. It samples wrErr at the first falling edge after the write edge. It samples outValid once at the falling edge after the second stage, where it must still be low, and reads the result at the falling edge after the third stage. The falling edge after that confirms the strobe has dropped and the outputs hold. For the boundary test, a code write is placed on the very edge that accepts a pair, and the bench expects the old gain on that pair and the new gain on the next one.

// File: rtl/xfeed_pkg.sv
`timescale 1ns/1ps
package xfeed_pkg;

  // Path order matches the write address decode.
  typedef enum logic [1:0] {
    PATH_LL = 2'd0,
    PATH_LR = 2'd1,
    PATH_RL = 2'd2,
    PATH_RR = 2'd3
  } path_e;

  localparam int NPATH     = 4;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int STEPS_PER_HALVING = 12;

  // Strobes from control to datapath, one per pipeline stage.
  typedef struct packed {
    logic capture;
    logic mulEn;
    logic sumEn;
  } xfeed_stb_t;

  // Q1.15 gain for each half-decibel step inside one halving interval.
  function automatic logic [GAIN_W-1:0] stepMantissa(input logic [3:0] k);
    case (k)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30935;
      4'd2:    return 16'd29205;
      4'd3:    return 16'd27571;
      4'd4:    return 16'd26029;
      4'd5:    return 16'd24573;
      4'd6:    return 16'd23198;
      4'd7:    return 16'd21900;
      4'd8:    return 16'd20675;
      4'd9:    return 16'd19519;
      4'd10:   return 16'd18427;
      4'd11:   return 16'd17396;
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/xfeed_ctrl.sv
`timescale 1ns/1ps
module xfeed_ctrl
  import xfeed_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [$clog2(NPATH)-1:0]          wrAddr,
  input  logic [CODE_W:0]                   wrData,
  input  logic                              inValid,
  output xfeed_stb_t                        stb,
  output logic [NPATH-1:0][CODE_W-1:0]      codes,
  output logic                              outValid,
  output logic                              wrErr
);

  localparam int ADDR_W = $clog2(NPATH);
  localparam logic [CODE_W-1:0] MUTE = {CODE_W{1'b1}};

  logic       badWrite;
  logic [2:0] stagePipe;

  assign badWrite = wrEn && wrData[CODE_W];

  // One code register per path; cross paths reset to mute.
  for (genvar g = 0; g < NPATH; g++) begin : g_code
    localparam logic [CODE_W-1:0] RST_CODE =
      (g == int'(PATH_LR) || g == int'(PATH_RL)) ? MUTE : '0;
    logic [CODE_W-1:0] codeQ;
    logic              hit;

    assign hit = wrEn && !wrData[CODE_W] && (wrAddr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    codeQ <= RST_CODE;
      else if (hit) codeQ <= wrData[CODE_W-1:0];
    end

    assign codes[g] = codeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr     <= 1'b0;
      stagePipe <= '0;
    end else begin
      wrErr     <= badWrite;
      stagePipe <= {stagePipe[1:0], inValid};
    end
  end

  assign stb.capture = inValid;
  assign stb.mulEn   = stagePipe[0];
  assign stb.sumEn   = stagePipe[1];
  assign outValid    = stagePipe[2];

endmodule

// File: rtl/xfeed_datapath.sv
`timescale 1ns/1ps
module xfeed_datapath
  import xfeed_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  xfeed_stb_t                   stb,
  input  logic signed [DATA_W-1:0]     inL,
  input  logic signed [DATA_W-1:0]     inR,
  input  logic [NPATH-1:0][CODE_W-1:0] codes,
  output logic signed [DATA_W-1:0]     outL,
  output logic signed [DATA_W-1:0]     outR
);

  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam int TERM_W = DATA_W + 1;
  localparam int SUM_W  = TERM_W + 1;
  localparam logic [CODE_W-1:0] MUTE  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] STEPS = CODE_W'(STEPS_PER_HALVING);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << GAIN_FRAC);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  function automatic logic [GAIN_W-1:0] codeToGain(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] octave;
    logic [CODE_W-1:0] step;
    octave = c / STEPS;
    step   = c % STEPS;
    if (c == '0)        return UNITY;
    else if (c == MUTE) return '0;
    else                return stepMantissa(step[3:0]) >> octave;
  endfunction

  function automatic logic signed [DATA_W-1:0] clampSum(input logic signed [SUM_W-1:0] s);
    if (s > SAT_HI)      return SAT_HI[DATA_W-1:0];
    else if (s < SAT_LO) return SAT_LO[DATA_W-1:0];
    else                 return s[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] smpL, smpR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpL <= '0;
      smpR <= '0;
    end else if (stb.capture) begin
      smpL <= inL;
      smpR <= inR;
    end
  end

  // Per path: gain snapshot at capture, weighted term one stage later.
  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [GAIN_W-1:0]        gainQ;
    logic signed [DATA_W-1:0] src;
    logic signed [PROD_W-1:0] prod;
    logic signed [TERM_W-1:0] termQ;

    assign src  = (g == int'(PATH_LL) || g == int'(PATH_LR)) ? smpL : smpR;
    assign prod = src * $signed({1'b0, gainQ});

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gainQ <= '0;
        termQ <= '0;
      end else begin
        if (stb.capture) gainQ <= codeToGain(codes[g]);
        if (stb.mulEn)   termQ <= prod[GAIN_FRAC +: TERM_W];
      end
    end
  end

  logic signed [SUM_W-1:0] sumL, sumR;

  assign sumL = $signed({g_path[PATH_LL].termQ[TERM_W-1], g_path[PATH_LL].termQ})
              + $signed({g_path[PATH_RL].termQ[TERM_W-1], g_path[PATH_RL].termQ});
  assign sumR = $signed({g_path[PATH_LR].termQ[TERM_W-1], g_path[PATH_LR].termQ})
              + $signed({g_path[PATH_RR].termQ[TERM_W-1], g_path[PATH_RR].termQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outL <= '0;
      outR <= '0;
    end else if (stb.sumEn) begin
      outL <= clampSum(sumL);
      outR <= clampSum(sumR);
    end
  end

endmodule

// File: rtl/xfeed_matrix.sv
`timescale 1ns/1ps
module xfeed_matrix
  import xfeed_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [CODE_W:0]          wrData,
  output logic                     wrErr,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inL,
  input  logic signed [DATA_W-1:0] inR,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outL,
  output logic signed [DATA_W-1:0] outR
);

  xfeed_stb_t                   stb;
  logic [NPATH-1:0][CODE_W-1:0] codes;

  xfeed_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .inValid  (inValid),
    .stb      (stb),
    .codes    (codes),
    .outValid (outValid),
    .wrErr    (wrErr)
  );

  xfeed_datapath #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .inL   (inL),
    .inR   (inR),
    .codes (codes),
    .outL  (outL),
    .outR  (outR)
  );

endmodule

// File: rtl/xfeed_matrix_chk.sv
`timescale 1ns/1ps
module xfeed_matrix_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 7
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [CODE_W:0]          wrData,
  input logic                     wrErr,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inL,
  input logic signed [DATA_W-1:0] inR,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outL,
  input logic signed [DATA_W-1:0] outR
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (!outValid && outL == '0 && outR == '0 && !wrErr));

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0) |-> (wrErr == $past(wrEn && wrData[CODE_W])));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> ($stable(outL) && $stable(outR)));

  assert_silent_in_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(inValid, 3) && $past(inL, 3) == '0 && $past(inR, 3) == '0)
      |-> (outL == '0 && outR == '0));

endmodule

bind xfeed_matrix xfeed_matrix_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .wrErr    (wrErr),
  .inValid  (inValid),
  .inL      (inL),
  .inR      (inR),
  .outValid (outValid),
  .outL     (outL),
  .outR     (outR)
);

// File: tb/xfeed_matrix_tb.sv
`timescale 1ns/1ps
module xfeed_matrix_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [1:0]         wrAddr = '0;
  logic [7:0]         wrData = '0;
  logic               wrErr;
  logic               inValid = 1'b0;
  logic signed [15:0] inL = '0;
  logic signed [15:0] inR = '0;
  logic               outValid;
  logic signed [15:0] outL, outR;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  xfeed_matrix u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrErr(wrErr), .inValid(inValid), .inL(inL), .inR(inR),
    .outValid(outValid), .outL(outL), .outR(outR)
  );

  // Stimulus: codes LL, LR, RL, RR then left and right samples.
  localparam int NVEC = 8;
  localparam logic [59:0] VECS [NVEC] = '{
    {7'd0,   7'd127, 7'd127, 7'd0,   16'sd1234,   -16'sd5678},
    {7'd127, 7'd0,   7'd0,   7'd127, 16'sd1000,   -16'sd2000},
    {7'd0,   7'd0,   7'd0,   7'd0,   16'sd30000,  16'sd30000},
    {7'd0,   7'd0,   7'd0,   7'd0,   -16'sd30000, -16'sd20000},
    {7'd12,  7'd24,  7'd1,   7'd126, 16'sd20000,  -16'sd16000},
    {7'd127, 7'd127, 7'd127, 7'd127, 16'sd12345,  -16'sd321},
    {7'd6,   7'd6,   7'd6,   7'd6,   -16'sd32768, 16'sd32767},
    {7'd0,   7'd0,   7'd0,   7'd0,   16'sd32767,  -16'sd32768}
  };

  function automatic longint gainRef(int c);
    int  k;
    int  oct;
    real m;
    if (c == 0)   return 32768;
    if (c == 127) return 0;
    k   = c % 12;
    oct = c / 12;
    m   = 32768.0 * (10.0 ** (-k / 40.0));
    return longint'($floor(m + 0.5)) >> oct;
  endfunction

  function automatic longint termRef(longint s, int c);
    return (s * gainRef(c)) >>> 15;
  endfunction

  function automatic longint satRef(longint s);
    if (s > 32767)  return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeByte(input logic [1:0] a, input logic [7:0] d, output logic errSeen);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    errSeen = wrErr;
  endtask

  task automatic sendPair(input logic signed [15:0] l, input logic signed [15:0] r,
                          input bit doWr, input logic [1:0] a, input logic [7:0] d,
                          output logic signed [15:0] gL, output logic signed [15:0] gR,
                          output logic early, output logic vld);
    @(negedge clk);
    inL = l; inR = r; inValid = 1'b1;
    if (doWr) begin wrEn = 1'b1; wrAddr = a; wrData = d; end
    @(negedge clk);
    inValid = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    early = outValid;
    @(negedge clk);
    vld = outValid; gL = outL; gR = outR;
  endtask

  task automatic loadCodes(input int ll, input int lr, input int rl, input int rr);
    logic e;
    writeByte(2'd0, 8'(ll), e);
    writeByte(2'd1, 8'(lr), e);
    writeByte(2'd2, 8'(rl), e);
    writeByte(2'd3, 8'(rr), e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic signed [15:0] gL, gR;
    logic early, vld, e;

    repeat (4) @(negedge clk);
    chk("R1", "outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outValid after reset", longint'(outValid), 0);
    chk("R1", "outL after reset", longint'(outL), 0);
    chk("R1", "outR after reset", longint'(outR), 0);
    chk("R1", "wrErr after reset", longint'(wrErr), 0);

    // R1 defaults give straight pass-through; R7 timing on the same pair.
    sendPair(16'sd4321, -16'sd777, 1'b0, 2'd0, 8'd0, gL, gR, early, vld);
    chk("R7", "outValid before third edge", longint'(early), 0);
    chk("R7", "outValid on third edge", longint'(vld), 1);
    chk("R1", "default left pass", longint'(gL), 4321);
    chk("R1", "default right pass", longint'(gR), -777);
    @(negedge clk);
    chk("R7", "outValid single cycle", longint'(outValid), 0);
    chk("R8", "outL held", longint'(outL), 4321);
    chk("R8", "outR held", longint'(outR), -777);

    // Vector table: R2 write order, R3 gain law, R4 mixing, R5 saturation.
    for (int i = 0; i < NVEC; i++) begin
      int ll, lr, rl, rr;
      longint sl, sr, expL, expR;
      ll = int'(VECS[i][59:53]); lr = int'(VECS[i][52:46]);
      rl = int'(VECS[i][45:39]); rr = int'(VECS[i][38:32]);
      sl = longint'($signed(VECS[i][31:16]));
      sr = longint'($signed(VECS[i][15:0]));
      expL = satRef(termRef(sl, ll) + termRef(sr, rl));
      expR = satRef(termRef(sl, lr) + termRef(sr, rr));
      loadCodes(ll, lr, rl, rr);
      sendPair(16'(sl), 16'(sr), 1'b0, 2'd0, 8'd0, gL, gR, early, vld);
      chk("R4", $sformatf("vector %0d outL (R2 R3 R5)", i), longint'(gL), expL);
      chk("R4", $sformatf("vector %0d outR (R2 R3 R5)", i), longint'(gR), expR);
    end
    // Direct R5 checks at the rails.
    chk("R5", "positive clamp expectation", satRef(termRef(30000, 0) + termRef(30000, 0)), 32767);

    // R6: rejected write raises a one-cycle flag and leaves codes intact.
    loadCodes(0, 127, 127, 0);
    writeByte(2'd0, 8'h85, e);
    chk("R6", "wrErr after bad write", longint'(e), 1);
    @(negedge clk);
    chk("R6", "wrErr drops after one cycle", longint'(wrErr), 0);
    writeByte(2'd3, 8'h05, e);
    chk("R6", "good write gives no flag", longint'(e), 0);
    writeByte(2'd3, 8'h00, e);
    writeByte(2'd0, 8'hFF, e);
    sendPair(16'sd9000, -16'sd3000, 1'b0, 2'd0, 8'd0, gL, gR, early, vld);
    chk("R6", "left unchanged after bad write", longint'(gL), 9000);
    chk("R6", "right unchanged after bad write", longint'(gR), -3000);

    // R9: write on the accepting edge applies only to later pairs.
    sendPair(16'sd5000, 16'sd6000, 1'b1, 2'd0, 8'd127, gL, gR, early, vld);
    chk("R9", "same-edge write not applied", longint'(gL), 5000);
    chk("R9", "other path unaffected", longint'(gR), 6000);
    sendPair(16'sd5000, 16'sd6000, 1'b0, 2'd0, 8'd0, gL, gR, early, vld);
    chk("R9", "write applied to next pair", longint'(gL), 0);
    chk("R9", "right still passes", longint'(gR), 6000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule